// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the status word of a small CPU core: eight single-bit flags and a three-bit interrupt priority level, eleven meaningful bits that appear on a 16-bit output word whose top five bits are always zero. The flags are negative, overflow, data length, index length, decimal mode, interrupt disable, zero and carry. Each flag keeps its value until one of four update sources writes it. In falling order of priority these sources are the interrupt-accept strobe, the set-by-mask and clear-by-mask operations, the single-flag set and clear commands for carry and interrupt disable, and per-flag writes from the ALU.

The block also gates interrupt requests. A maskable request passes only while interrupt disable is clear. Three exempt sources pass at all times: address-match detection, the watchdog timer and divide-by-zero. The gate result is registered. The index-length flag is also driven on its own output so the datapath can choose the width of its index registers: 0 selects 16 bits and 1 selects 8 bits.

Top module: `psr_core`

## Requirements
- R1: A synchronous active-high reset sets interrupt disable (bit 2) to 1 and clears decimal mode (bit 3), index length (bit 4), data length (bit 5), overflow (bit 6), negative (bit 7), the priority level (bits 10..8) and `irq_pass`. The reset values of carry (bit 0) and zero (bit 1) come from the parameter `CZ_RESET` and are not defined beyond that.
- R2: Bits 15..11 of `psr_word` always read as zero.
- R3: When `alu_we[b]` is 1, flag b (bit b of `psr_word`, for b from 0 to 7) takes the value of `alu_val[b]` at the next clock edge. A flag whose enable is 0 keeps its value.
- R4: `mask_set` sets every flag whose bit in `mask_bits` is 1, and `mask_clr` clears every such flag. If both operations are active on the same bit in one cycle, clear takes effect.
- R5: `set_carry` and `clr_carry` write bit 0, and `set_idis` and `clr_idis` write bit 2. If set and clear of the same flag are active together, clear takes effect.
- R6: For any one flag, the mask operations take priority over the single-flag commands, and the single-flag commands take priority over ALU writes.
- R7: `irq_accept` forces interrupt disable to 1 at the next edge, regardless of any clear in the same cycle, and loads `accept_ipl` into bits 10..8.
- R8: `irq_pass` is registered. One cycle after a nonzero `mask_req`, it is 1 if interrupt disable was 0 at that edge and 0 otherwise, provided no exempt source is active.
- R9: A request on `addr_match_req`, `wdt_req` or `div0_req` makes `irq_pass` 1 at the next edge, whatever the value of interrupt disable.
- R10: `x_flag` always equals bit 4 of `psr_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_we | input | 8 | Per-flag write enables from the ALU |
| alu_val | input | 8 | Flag values from the ALU |
| mask_set | input | 1 | Set the flags selected by mask_bits |
| mask_clr | input | 1 | Clear the flags selected by mask_bits |
| mask_bits | input | 8 | Flag selection mask |
| set_carry | input | 1 | Set carry |
| clr_carry | input | 1 | Clear carry |
| set_idis | input | 1 | Set interrupt disable |
| clr_idis | input | 1 | Clear interrupt disable |
| irq_accept | input | 1 | Interrupt accepted strobe |
| accept_ipl | input | 3 | Priority level loaded on accept |
| mask_req | input | 4 | Maskable interrupt requests |
| addr_match_req | input | 1 | Address-match request, never masked |
| wdt_req | input | 1 | Watchdog request, never masked |
| div0_req | input | 1 | Divide-by-zero request, never masked |
| psr_word | output | 16 | Status word |
| x_flag | output | 1 | Index length flag |
| irq_pass | output | 1 | Registered interrupt gate result |

## Verification
The properties assume that every input is a known value at each edge once reset is released. They also assume that a mask check applies only when no interrupt accept or opposing clear hits the same bit in that cycle, and each property states these conditions in its own antecedent. The stimulus drives every input from a task a short time after the rising edge and returns all commands to zero between scenarios, so each cycle carries exactly the combination under test. The bench first clears carry and zero with a mask clear, so no later check depends on their undefined reset value.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int FLAG_W = 8;
  localparam int IPL_W  = 3;
  localparam int BIT_C  = 0;
  localparam int BIT_Z  = 1;
  localparam int BIT_I  = 2;
  localparam int BIT_D  = 3;
  localparam int BIT_X  = 4;
  localparam int BIT_M  = 5;
  localparam int BIT_V  = 6;
  localparam int BIT_N  = 7;
  localparam int EXEMPT_W = 3;
endpackage

// File: rtl/psr_flag_next.sv
module psr_flag_next
  import psr_pkg::*;
(
  input  logic [FLAG_W-1:0] cur,
  input  logic [FLAG_W-1:0] alu_we,
  input  logic [FLAG_W-1:0] alu_val,
  input  logic              mask_set,
  input  logic              mask_clr,
  input  logic [FLAG_W-1:0] mask_bits,
  input  logic [FLAG_W-1:0] one_set,
  input  logic [FLAG_W-1:0] one_clr,
  input  logic              force_i,
  output logic [FLAG_W-1:0] nxt
);
  logic [FLAG_W-1:0] m_set;
  logic [FLAG_W-1:0] m_clr;

  assign m_set = mask_set ? mask_bits : '0;
  assign m_clr = mask_clr ? mask_bits : '0;

  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    always_comb begin
      nxt[b] = cur[b];
      if (alu_we[b])      nxt[b] = alu_val[b];
      if (one_set[b])     nxt[b] = 1'b1;
      if (one_clr[b])     nxt[b] = 1'b0;
      if (m_set[b])       nxt[b] = 1'b1;
      if (m_clr[b])       nxt[b] = 1'b0;
      if (b == BIT_I && force_i) nxt[b] = 1'b1;
    end
  end
endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate
  import psr_pkg::*;
#(
  parameter int REQ_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                idis,
  input  logic [REQ_W-1:0]    req,
  input  logic [EXEMPT_W-1:0] exempt,
  output logic                pass
);
  always_ff @(posedge clk) begin
    if (rst) pass <= 1'b0;
    else     pass <= (|exempt) | ((|req) & ~idis);
  end
endmodule

// File: rtl/psr_core.sv
module psr_core
  import psr_pkg::*;
#(
  parameter int         WORD_W   = 16,
  parameter int         MREQ_W   = 4,
  parameter logic [1:0] CZ_RESET = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        alu_we,
  input  logic [7:0]        alu_val,
  input  logic              mask_set,
  input  logic              mask_clr,
  input  logic [7:0]        mask_bits,
  input  logic              set_carry,
  input  logic              clr_carry,
  input  logic              set_idis,
  input  logic              clr_idis,
  input  logic              irq_accept,
  input  logic [2:0]        accept_ipl,
  input  logic [MREQ_W-1:0] mask_req,
  input  logic              addr_match_req,
  input  logic              wdt_req,
  input  logic              div0_req,
  output logic [WORD_W-1:0] psr_word,
  output logic              x_flag,
  output logic              irq_pass
);
  localparam int PAD_W = WORD_W - FLAG_W - IPL_W;
  localparam logic [FLAG_W-1:0] FLAG_RST =
    FLAG_W'((1 << BIT_I) | (int'(CZ_RESET[1]) << BIT_Z) | (int'(CZ_RESET[0]) << BIT_C));

  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [IPL_W-1:0]  ipl_q;
  logic [FLAG_W-1:0] one_set, one_clr;

  always_comb begin
    one_set        = '0;
    one_clr        = '0;
    one_set[BIT_C] = set_carry;
    one_clr[BIT_C] = clr_carry;
    one_set[BIT_I] = set_idis;
    one_clr[BIT_I] = clr_idis;
  end

  psr_flag_next u_next (
    .cur      (flags_q),
    .alu_we   (alu_we),
    .alu_val  (alu_val),
    .mask_set (mask_set),
    .mask_clr (mask_clr),
    .mask_bits(mask_bits),
    .one_set  (one_set),
    .one_clr  (one_clr),
    .force_i  (irq_accept),
    .nxt      (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= FLAG_RST;
      ipl_q   <= '0;
    end else begin
      flags_q <= flags_d;
      if (irq_accept) ipl_q <= accept_ipl;
    end
  end

  psr_irq_gate #(.REQ_W(MREQ_W)) u_gate (
    .clk   (clk),
    .rst   (rst),
    .idis  (flags_q[BIT_I]),
    .req   (mask_req),
    .exempt({addr_match_req, wdt_req, div0_req}),
    .pass  (irq_pass)
  );

  assign psr_word = {{PAD_W{1'b0}}, ipl_q, flags_q};
  assign x_flag   = flags_q[BIT_X];
endmodule

// File: rtl/psr_core_chk.sv
module psr_core_chk #(
  parameter int WORD_W = 16,
  parameter int MREQ_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mask_set,
  input logic              mask_clr,
  input logic [7:0]        mask_bits,
  input logic              irq_accept,
  input logic [MREQ_W-1:0] mask_req,
  input logic              addr_match_req,
  input logic              wdt_req,
  input logic              div0_req,
  input logic [WORD_W-1:0] psr_word,
  input logic              x_flag,
  input logic              irq_pass
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst === 1'bx)
    rst |=> (psr_word[2] && !psr_word[3] && !psr_word[4] && !irq_pass));

  p_top_zero_r2: assert property (@(posedge clk) disable iff (rst)
    psr_word[WORD_W-1:11] == '0);

  p_mask_set_r4: assert property (@(posedge clk) disable iff (rst)
    (mask_set && !mask_clr && mask_bits[7]) |=> psr_word[7]);

  p_mask_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (mask_clr && mask_bits[3]) |=> !psr_word[3]);

  p_accept_sets_i_r7: assert property (@(posedge clk) disable iff (rst)
    irq_accept |=> psr_word[2]);

  p_masked_block_r8: assert property (@(posedge clk) disable iff (rst)
    (psr_word[2] && !addr_match_req && !wdt_req && !div0_req) |=> !irq_pass);

  p_open_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (!psr_word[2] && (|mask_req)) |=> irq_pass);

  p_exempt_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (addr_match_req || wdt_req || div0_req) |=> irq_pass);

  p_xflag_mirror_r10: assert property (@(posedge clk) disable iff (rst)
    x_flag == psr_word[4]);
endmodule

bind psr_core psr_core_chk #(.WORD_W(WORD_W), .MREQ_W(MREQ_W)) u_chk (
  .clk(clk), .rst(rst), .mask_set(mask_set), .mask_clr(mask_clr),
  .mask_bits(mask_bits), .irq_accept(irq_accept), .mask_req(mask_req),
  .addr_match_req(addr_match_req), .wdt_req(wdt_req), .div0_req(div0_req),
  .psr_word(psr_word), .x_flag(x_flag), .irq_pass(irq_pass)
);

// File: tb/psr_core_test.sv
`timescale 1ns/1ps
module psr_core_test;
  logic clk = 1'b0;
  logic rst;
  logic [7:0] alu_we, alu_val, mask_bits;
  logic mask_set, mask_clr, set_carry, clr_carry, set_idis, clr_idis;
  logic irq_accept;
  logic [2:0] accept_ipl;
  logic [3:0] mask_req;
  logic addr_match_req, wdt_req, div0_req;
  logic [15:0] psr_word;
  logic x_flag, irq_pass;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  psr_core uut (
    .clk(clk), .rst(rst), .alu_we(alu_we), .alu_val(alu_val),
    .mask_set(mask_set), .mask_clr(mask_clr), .mask_bits(mask_bits),
    .set_carry(set_carry), .clr_carry(clr_carry), .set_idis(set_idis),
    .clr_idis(clr_idis), .irq_accept(irq_accept), .accept_ipl(accept_ipl),
    .mask_req(mask_req), .addr_match_req(addr_match_req), .wdt_req(wdt_req),
    .div0_req(div0_req), .psr_word(psr_word), .x_flag(x_flag), .irq_pass(irq_pass)
  );

  task automatic idle();
    alu_we = '0; alu_val = '0; mask_bits = '0; mask_set = 0; mask_clr = 0;
    set_carry = 0; clr_carry = 0; set_idis = 0; clr_idis = 0;
    irq_accept = 0; accept_ipl = '0; mask_req = '0;
    addr_match_req = 0; wdt_req = 0; div0_req = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    idle();
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_word(string req, logic [15:0] exp);
    chk(req, psr_word, exp);
    chk("R2", {11'd0, psr_word[15:11]}, 16'h0000);
    chk("R10", {15'd0, x_flag}, {15'd0, psr_word[4]});
  endtask

  task automatic t_reset();
    rst = 1; idle(); step(); step();
    chk("R1", psr_word & 16'hFFFC, 16'h0004);
    chk("R1", {15'd0, irq_pass}, 16'h0000);
    rst = 0;
    mask_clr = 1; mask_bits = 8'h03; step();
    chk_word("R4", 16'h0004);
  endtask

  task automatic t_alu();
    alu_we = 8'hC3; alu_val = 8'h81; step();
    chk_word("R3", 16'h0085);
    alu_we = 8'h01; alu_val = 8'h00; step();
    chk_word("R3", 16'h0084);
  endtask

  task automatic t_mask();
    mask_set = 1; mask_bits = 8'h38; step();
    chk_word("R4", 16'h00BC);
    chk("R10", {15'd0, x_flag}, 16'h0001);
    mask_set = 1; mask_clr = 1; mask_bits = 8'h08; step();
    chk_word("R4", 16'h00B4);
    mask_clr = 1; mask_bits = 8'hFF; step();
    chk_word("R4", 16'h0000);
    chk("R10", {15'd0, x_flag}, 16'h0000);
  endtask

  task automatic t_single();
    set_carry = 1; step();
    chk_word("R5", 16'h0001);
    set_carry = 1; clr_carry = 1; step();
    chk_word("R5", 16'h0000);
    set_idis = 1; step();
    chk_word("R5", 16'h0004);
    clr_idis = 1; step();
    chk_word("R5", 16'h0000);
  endtask

  task automatic t_prio();
    mask_set = 1; mask_bits = 8'h01; clr_carry = 1; step();
    chk_word("R6", 16'h0001);
    mask_clr = 1; mask_bits = 8'h01; set_carry = 1; alu_we = 8'h01; alu_val = 8'h01; step();
    chk_word("R6", 16'h0000);
    set_carry = 1; alu_we = 8'h01; alu_val = 8'h00; step();
    chk_word("R6", 16'h0001);
  endtask

  task automatic t_accept();
    irq_accept = 1; accept_ipl = 3'd5; clr_idis = 1; mask_clr = 1; mask_bits = 8'h04; step();
    chk_word("R7", 16'h0505);
    clr_idis = 1; step();
    chk_word("R7", 16'h0501);
  endtask

  task automatic t_gate();
    mask_req = 4'b0100; step();
    chk("R8", {15'd0, irq_pass}, 16'h0001);
    mask_req = 4'b0001; set_idis = 1; step();
    chk("R8", {15'd0, irq_pass}, 16'h0001);
    mask_req = 4'b1000; step();
    chk("R8", {15'd0, irq_pass}, 16'h0000);
    wdt_req = 1; step();
    chk("R9", {15'd0, irq_pass}, 16'h0001);
    step();
    chk("R8", {15'd0, irq_pass}, 16'h0000);
    div0_req = 1; mask_req = 4'b0010; step();
    chk("R9", {15'd0, irq_pass}, 16'h0001);
    addr_match_req = 1; step();
    chk("R9", {15'd0, irq_pass}, 16'h0001);
    chk_word("R9", 16'h0505);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_alu();
    t_mask();
    t_single();
    t_prio();
    t_accept();
    t_gate();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule